// File: doc/BRIEF.md
# Watchdog Event Reset Router

A watchdog timeout arrives as a one-cycle event. This block turns that event into a single core-level action. A 3-bit operating mode in a small control register selects the action. The action can be nothing, a local core reset, a non-maskable interrupt, or a whole-device reset. A fourth choice is an interrupt followed by a local reset after a programmable wait. Every action appears as a one-cycle request pulse on its own output, for the reset and interrupt logic that follows.

Software reaches the register through a single-word write strobe and a combinational read bus. The register holds:

- a sticky flag that records that a watchdog event happened, cleared by writing one to a clear bit;
- a lock bit that freezes the configuration until the timer reset releases it;
- a delay exponent.

The delay exponent sets the interrupt-to-reset gap in ticks of an internal divide-by-`DIV_RATIO` enable. The gap is `2^(BASE_SHIFT+delay)` ticks, which is 256 to 32768 ticks with the default parameters.

Top module: `wdt_evt_router`

## Requirements
- R1: After reset the read word is 0x0000_0080: delay field 100b, mode 000b, status 0, lock 0. All three action outputs are low.
- R2: In mode 010b (bits 3:1), an event makes `local_rst_o` high for exactly the one cycle after the event edge. No other output pulses.
- R3: In mode 011b, an event makes `nmi_o` high for exactly one cycle after the event edge. No other output pulses.
- R4: In mode 101b, an event makes `dev_rst_o` high for exactly one cycle after the event edge. No other output pulses.
- R5: In modes 000b, 001b, 110b and 111b, an event causes no output pulse.
- R6: In mode 100b, an event gives an `nmi_o` pulse one cycle after the event edge. A `local_rst_o` pulse follows exactly `2^(BASE_SHIFT+D)*DIV_RATIO` cycles after the `nmi_o` pulse, where D is the delay field in bits 7:5. This holds for every value of D.
- R7: While an interrupt-to-reset wait is running, further events produce no output pulse and do not restart the wait.
- R8: The status bit (bit 4) becomes 1 on the edge that samples an event. A write with bit 9 set clears it. A write with bit 9 clear leaves it unchanged. An event in the same cycle as a clear leaves it at 1.
- R9: A write sets lock (bit 0), mode (bits 3:1) and delay (bits 7:5) from the write data. Bits 8, 9 and 31:10 always read as zero.
- R10: While lock reads 1, writes leave lock, mode and delay unchanged, and the configured action still fires. A write with bit 9 set still clears the status.
- R11: A cycle with `lock_release_i` high clears the lock bit. After that, writes take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_release_i | input | 1 | Timer-reset indication; clears the lock bit |
| wd_event_i | input | 1 | One-cycle watchdog timeout event |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| local_rst_o | output | 1 | Local core reset request pulse |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |
| dev_rst_o | output | 1 | Device reset request pulse |

## Verification
The hardest case to reach from the ports is an event that arrives while an interrupt-to-reset wait is already counting. No flag shows that the wait is running. The bench therefore arms the combined mode with a known delay and fires a second event a few cycles into the wait. It then checks that no second interrupt appears and that the reset still lands on the cycle computed from the first event. The bench uses a reduced base shift so that all eight delay values can be timed exactly, cycle by cycle, within the run.

// File: rtl/wer_pkg.sv
package wer_pkg;
  localparam int unsigned DLY_W    = 3;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned LOCK_BIT = 0;
  localparam int unsigned MODE_LSB = 1;
  localparam int unsigned STAT_BIT = 4;
  localparam int unsigned DLY_LSB  = 5;
  localparam int unsigned CLR_BIT  = 9;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF      = 3'b000,
    MODE_LRST     = 3'b010,
    MODE_NMI      = 3'b011,
    MODE_NMI_LRST = 3'b100,
    MODE_DEVRST   = 3'b101
  } mode_e;

  localparam logic [DLY_W-1:0] DLY_RST = 3'b100;
endpackage

// File: rtl/wer_tick_gen.sv
module wer_tick_gen #(
  parameter int unsigned DIV_RATIO = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;

  // phase restarts on every wait start so the gap is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= '0;
    else if (run_i)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && !start_i && (cnt_q == LAST);
endmodule

// File: rtl/wer_ctrl_reg.sv
module wer_ctrl_reg
  import wer_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lock_release_i,
  input  logic                 wd_event_i,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [MODE_W-1:0]    mode_o,
  output logic [DLY_W-1:0]     dly_o,
  output logic [REG_W-1:0]     rdata_o
);
  logic              lock_q, stat_q;
  logic [MODE_W-1:0] mode_q;
  logic [DLY_W-1:0]  dly_q;
  logic              cfg_we, clr_req;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[REG_W-1:CLR_BIT+1], wdata_i[CLR_BIT-1]};
  assign cfg_we  = wr_en_i && !lock_q;
  assign clr_req = wr_en_i && wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      dly_q  <= DLY_RST;
    end else if (cfg_we) begin
      mode_q <= wdata_i[MODE_LSB +: MODE_W];
      dly_q  <= wdata_i[DLY_LSB +: DLY_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lock_q <= 1'b0;
    else if (lock_release_i) lock_q <= 1'b0;
    else if (cfg_we)         lock_q <= wdata_i[LOCK_BIT];
  end

  // new event beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= 1'b0;
    else if (wd_event_i) stat_q <= 1'b1;
    else if (clr_req)    stat_q <= 1'b0;
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[LOCK_BIT]             = lock_q;
    rdata_o[MODE_LSB +: MODE_W]   = mode_q;
    rdata_o[STAT_BIT]             = stat_q;
    rdata_o[DLY_LSB +: DLY_W]     = dly_q;
  end

  assign mode_o = mode_q;
  assign dly_o  = dly_q;
endmodule

// File: rtl/wer_action_seq.sv
module wer_action_seq
  import wer_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wd_event_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              tick_i,
  output logic              start_o,
  output logic              pending_o,
  output logic              local_rst_o,
  output logic              nmi_o,
  output logic              dev_rst_o
);
  localparam int unsigned CNT_W = BASE_SHIFT + (1 << DLY_W);

  logic             pending_q, accept;
  logic [CNT_W-1:0] remain_q;
  logic             lrst_q, nmi_q, dev_q;

  assign accept  = wd_event_i && !pending_q;
  assign start_o = accept && (mode_i == MODE_NMI_LRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      remain_q  <= '0;
      lrst_q    <= 1'b0;
      nmi_q     <= 1'b0;
      dev_q     <= 1'b0;
    end else begin
      lrst_q <= 1'b0;
      nmi_q  <= 1'b0;
      dev_q  <= 1'b0;
      if (accept) begin
        unique case (mode_i)
          MODE_LRST:   lrst_q <= 1'b1;
          MODE_NMI:    nmi_q  <= 1'b1;
          MODE_DEVRST: dev_q  <= 1'b1;
          MODE_NMI_LRST: begin
            nmi_q     <= 1'b1;
            pending_q <= 1'b1;
            remain_q  <= CNT_W'(1) << (BASE_SHIFT + 32'(dly_i));
          end
          default: ;
        endcase
      end else if (pending_q && tick_i) begin
        if (remain_q == CNT_W'(1)) begin
          lrst_q    <= 1'b1;
          pending_q <= 1'b0;
        end
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign pending_o   = pending_q;
  assign local_rst_o = lrst_q;
  assign nmi_o       = nmi_q;
  assign dev_rst_o   = dev_q;
endmodule

// File: rtl/wdt_evt_router.sv
module wdt_evt_router
  import wer_pkg::*;
#(
  parameter int unsigned DIV_RATIO  = 6,
  parameter int unsigned BASE_SHIFT = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lock_release_i,
  input  logic        wd_event_i,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        local_rst_o,
  output logic        nmi_o,
  output logic        dev_rst_o
);
  logic [MODE_W-1:0] mode;
  logic [DLY_W-1:0]  dly;
  logic              tick, start, pending;

  wer_ctrl_reg u_reg (
    .clk_i, .rst_ni, .lock_release_i, .wd_event_i, .wr_en_i, .wdata_i,
    .mode_o (mode),
    .dly_o  (dly),
    .rdata_o
  );

  wer_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk_i, .rst_ni,
    .start_i (start),
    .run_i   (pending),
    .tick_o  (tick)
  );

  wer_action_seq #(.BASE_SHIFT(BASE_SHIFT)) u_seq (
    .clk_i, .rst_ni, .wd_event_i,
    .mode_i      (mode),
    .dly_i       (dly),
    .tick_i      (tick),
    .start_o     (start),
    .pending_o   (pending),
    .local_rst_o, .nmi_o, .dev_rst_o
  );
endmodule

// File: rtl/wer_checker.sv
module wer_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lock_release_i,
  input logic       wd_event_i,
  input logic [7:0] rdata_i,
  input logic       local_rst_i,
  input logic       nmi_i,
  input logic       dev_rst_i
);
  a_r2_lrst_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_rst_i |=> !local_rst_i);

  a_r3_nmi_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !nmi_i);

  a_r4_dev_follows_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |-> $past(wd_event_i));

  a_r5_single_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({local_rst_i, nmi_i, dev_rst_i}));

  a_r8_status_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_event_i |=> rdata_i[4]);

  a_r10_locked_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i[0] && !lock_release_i) |=> ($stable(rdata_i[3:0]) && $stable(rdata_i[7:5])));

  a_r11_release_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_release_i |=> !rdata_i[0]);
endmodule

bind wdt_evt_router wer_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lock_release_i (lock_release_i),
  .wd_event_i     (wd_event_i),
  .rdata_i        (rdata_o[7:0]),
  .local_rst_i    (local_rst_o),
  .nmi_i          (nmi_o),
  .dev_rst_i      (dev_rst_o)
);

// File: tb/wdt_evt_router_test.sv
`timescale 1ns/1ps
module wdt_evt_router_test;
  localparam int DIV = 6;
  localparam int BS  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rel = 1'b0, evt = 1'b0, we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic lrst, nmi, dev;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wdt_evt_router #(.DIV_RATIO(DIV), .BASE_SHIFT(BS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lock_release_i(rel), .wd_event_i(evt),
    .wr_en_i(we), .wdata_i(wd), .rdata_o(rd),
    .local_rst_o(lrst), .nmi_o(nmi), .dev_rst_o(dev)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  // fire event; return outputs {lrst,nmi,dev} in cycles 1 and 2 after the edge
  task automatic fire(output logic [2:0] c1, output logic [2:0] c2);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0; c1 = {lrst, nmi, dev};
    @(negedge clk); c2 = {lrst, nmi, dev};
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    logic [2:0] c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd == 32'h80, "R1 reset word", rd, 32'h80);
    chk({lrst, nmi, dev} == 3'b000, "R1 outputs idle", {lrst, nmi, dev}, 0);

    // every mode except the combined one
    for (int m = 0; m < 8; m++) begin
      logic [2:0] exp;
      if (m == 4) continue;
      wr(32'(m) << 1);
      fire(c1, c2);
      exp = (m == 2) ? 3'b100 : (m == 3) ? 3'b010 : (m == 5) ? 3'b001 : 3'b000;
      chk(c1 == exp, (m == 2) ? "R2 lrst pulse" : (m == 3) ? "R3 nmi pulse" :
          (m == 5) ? "R4 dev pulse" : "R5 no action", c1, exp);
      chk(c2 == 3'b000, "R2/R3/R4 one cycle only", c2, 0);
      wr(32'h200);
    end

    // combined mode, every delay
    for (int d = 0; d < 8; d++) begin
      int gap, expg;
      bit nmi_ok;
      expg = (1 << (BS + d)) * DIV;
      wr((32'(d) << 5) | (32'd4 << 1));
      @(negedge clk); evt = 1'b1;
      @(negedge clk); evt = 1'b0;
      nmi_ok = nmi && !lrst;
      gap = -1;
      for (int k = 1; k <= expg + 20; k++) begin
        @(negedge clk);
        if (lrst) begin gap = k; break; end
      end
      chk(nmi_ok, "R6 nmi first", nmi_ok, 1);
      chk(gap == expg, "R6 gap", gap, expg);
    end

    // R7: second event during the wait
    begin
      int gap, expg;
      bit extra;
      expg = (1 << BS) * DIV;
      wr(32'd4 << 1);
      @(negedge clk); evt = 1'b1;
      @(negedge clk); evt = 1'b0;
      extra = 1'b0; gap = -1;
      for (int k = 1; k <= expg + 20; k++) begin
        if (k == 5) evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
        if (nmi || dev) extra = 1'b1;
        if (lrst) begin gap = k; break; end
      end
      chk(!extra, "R7 no output during wait", extra, 0);
      chk(gap == expg, "R7 wait not restarted", gap, expg);
      repeat (expg + 10) begin
        @(negedge clk);
        if (lrst) extra = 1'b1;
      end
      chk(!extra, "R7 no second reset", extra, 0);
    end

    // R8 status
    wr(32'h200);
    chk(rd[4] == 1'b0, "R8 cleared", rd[4], 0);
    wr(32'h0);
    fire(c1, c2);
    chk(rd[4] == 1'b1, "R8 set by event", rd[4], 1);
    wr(32'h0);
    chk(rd[4] == 1'b1, "R8 write 0 no effect", rd[4], 1);
    @(negedge clk); evt = 1'b1; we = 1'b1; wd = 32'h200;
    @(negedge clk); evt = 1'b0; we = 1'b0; wd = '0;
    chk(rd[4] == 1'b1, "R8 event wins", rd[4], 1);
    wr(32'h200);
    chk(rd[4] == 1'b0, "R8 clear", rd[4], 0);

    // R9 layout
    wr(32'hFFFF_FFFE);
    chk(rd == 32'hEE, "R9 fields and reserved zero", rd, 32'hEE);
    wr(32'h0000_00A4);
    chk(rd == 32'hA4, "R9 field write", rd, 32'hA4);

    // R10 lock
    wr(32'h7);
    chk(rd == 32'h7, "R10 lock set", rd, 32'h7);
    wr(32'h4);
    chk(rd == 32'h7, "R10 write ignored", rd, 32'h7);
    fire(c1, c2);
    chk(c1 == 3'b010, "R10 locked mode fires", c1, 3'b010);
    chk(rd == 32'h17, "R10 status while locked", rd, 32'h17);
    wr(32'h200);
    chk(rd == 32'h7, "R10 clear while locked", rd, 32'h7);

    // R11 release
    @(negedge clk); rel = 1'b1;
    @(negedge clk); rel = 1'b0;
    chk(rd == 32'h6, "R11 unlocked", rd, 32'h6);
    wr(32'hA);
    chk(rd == 32'hA, "R11 write after release", rd, 32'hA);
    fire(c1, c2);
    wr(32'h200);
    chk(c1 == 3'b001, "R11 new mode active", c1, 3'b001);

    summary();
  end
endmodule